// File: doc/BRIEF.md
# Timer tick prescaler and divider

This block turns one base clock into five per-channel count-enable strobes for a five-channel PWM timer. Two 8-bit prescalers divide the base clock by their value plus one. Channels 0 and 1 hang off prescaler A, and channels 2, 3 and 4 hang off prescaler B. Behind its prescaler, every channel has its own 4-bit select code. The code either divides the prescaled tick by a power of two or hands the channel over to an external tick input. External input 0 belongs to the group of channels 0 to 1, and input 1 belongs to the group of channels 2 to 4.

The configuration arrives as two words. `cfg_pre` carries the low 16 bits of the prescaler word, with one byte per prescaler. `cfg_sel` carries the low 20 bits of the select word, with one nibble per channel. Each output is a one-clock enable strobe in the base clock domain. It is not a derived clock. Changes are staged so that a running count is never cut short.

Each channel is a two-state machine:
- MODE_DIV counts prescaled ticks up to its limit.
- MODE_EXT forwards the group's external tick.

The transition from MODE_DIV is taken at the end of a divide period. The transition from MODE_EXT is taken at a prescaler terminal count. On either transition the channel re-reads its select code and enters MODE_EXT if the code is marked external, or MODE_DIV with a fresh divide amount if it is not. Reset puts every channel in MODE_DIV with code 0 and empties both prescalers.

Top module: `pwm_tick_gen`

## Requirements
- R1: Prescaler A takes its value from `cfg_pre[7:0]` and drives channels 0 and 1. Prescaler B takes its value from `cfg_pre[15:8]` and drives channels 2 to 4.
- R2: A prescaler with value p emits one prescaled tick every p+1 base clocks. A value of 0 yields a tick on every clock.
- R3: The select code of channel c is `cfg_sel[4c+3:4c]`.
- R4: For a select code s that is not marked external, the channel strobes once every (p+1)·2^(s+DIV_BASE) base clocks, where DIV_BASE defaults to 1. Code 5 is not external by default, so it gives a divide by 64.
- R5: With a code marked in EXT_MASK (by default only code 4), the channel strobes exactly one clock after each cycle in which its group's external input is high. The other group's external input has no effect on it.
- R6: A new prescaler value is taken only at that prescaler's next terminal count. The count already in progress finishes unchanged.
- R7: A new select code is taken in MODE_DIV only at the end of the current divide period, and in MODE_EXT only at the next prescaler terminal count.
- R8: In MODE_DIV with a divide of 2 or more, each strobe lasts exactly one clock.
- R9: While reset is held all strobes are low. After reset every channel strobes once every 2^DIV_BASE clocks until it is reconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre | input | 16 | Prescaler values, one byte per group |
| cfg_sel | input | 20 | Per-channel 4-bit select codes |
| ext_tick | input | 2 | Synchronous external tick pulses, one per group |
| tick | output | 5 | One-clock count-enable strobe per channel |

## Verification
The bench checks the divider path with several prescaler and select combinations:
- Small and large prescaler values.
- Every channel on a different code.
- Code 5, which the mask does not mark, so it must divide rather than switch to external.

Because each channel's expected period is a distinct product, a mix-up between the groups or the nibble positions shows up as a wrong interval. Single external pulses on each input separate the external path from the divider path and show that the two groups are isolated. Changing the prescaler value or the select code in the middle of a period tells a deferred update apart from an immediate one: the interval that straddles the change has a length that only the deferred form produces.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    typedef enum logic {
        MODE_DIV = 1'b0,
        MODE_EXT = 1'b1
    } tick_mode_e;

    // Channels below the split use prescaler/external input 0, the rest use 1.
    function automatic int group_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pwm_tick_prescaler.sv
module pwm_tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div_val,
    output logic             pre_tick
);

    localparam logic [PRE_W-1:0] DEC_ONE = 1;

    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = (cnt_q == '0);

    // The reload value is sampled only at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= div_val;
        end else begin
            cnt_q <= cnt_q - DEC_ONE;
        end
    end

    // R2
    gap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && div_val != '0) |=> !pre_tick);

    // R2
    every_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && div_val == '0) |=> pre_tick);

endmodule

// File: rtl/pwm_tick_chan.sv
module pwm_tick_chan
    import pwm_tick_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int DIV_BASE = 1,
    parameter int SHW      = 5,
    parameter int CNT_W    = 16,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             ext_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam logic [CNT_W-1:0] CNT_ONE  = 1;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [SHW-1:0]   SH_BASE  = SHW'(DIV_BASE);

    tick_mode_e       mode_q, mode_d;
    logic [SHW-1:0]   shift_q, shift_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, lim;
    logic             sel_ext, at_end, tick_d, tick_q;

    assign sel_ext = EXT_MASK[sel];
    assign lim     = ~(ALL_ONES << shift_q);
    assign at_end  = pre_tick && (cnt_q == lim);

    always_comb begin
        mode_d  = mode_q;
        shift_d = shift_q;
        cnt_d   = cnt_q;
        tick_d  = 1'b0;
        unique case (mode_q)
            MODE_DIV: begin
                if (at_end) begin
                    tick_d = 1'b1;
                    cnt_d  = '0;
                    mode_d = sel_ext ? MODE_EXT : MODE_DIV;
                    if (!sel_ext) shift_d = SHW'(sel) + SH_BASE;
                end else if (pre_tick) begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            MODE_EXT: begin
                tick_d = ext_in;
                if (pre_tick) begin
                    cnt_d  = '0;
                    mode_d = sel_ext ? MODE_EXT : MODE_DIV;
                    if (!sel_ext) shift_d = SHW'(sel) + SH_BASE;
                end
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_DIV;
            shift_q <= SH_BASE;
            cnt_q   <= '0;
        end else begin
            mode_q  <= mode_d;
            shift_q <= shift_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign tick = tick_q;

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && mode_q == MODE_DIV && shift_q != '0) |=> !tick_q);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DIV) |-> (cnt_q <= lim));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int N_CH      = 5,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int GRP_SPLIT = 2,
    parameter int DIV_BASE  = 1,
    parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*PRE_W-1:0]    cfg_pre,
    input  logic [N_CH*SEL_W-1:0] cfg_sel,
    input  logic [1:0]            ext_tick,
    output logic [N_CH-1:0]       tick
);

    localparam int N_GRP = 2;
    localparam int SHW   = $clog2((1 << SEL_W) + DIV_BASE);
    localparam int CNT_W = (1 << SEL_W) - 1 + DIV_BASE;

    logic [N_GRP-1:0] pre_tick;

    for (genvar g = 0; g < N_GRP; g++) begin : g_pre
        pwm_tick_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_val  (cfg_pre[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick[g])
        );
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int G = group_of(c, GRP_SPLIT);

        pwm_tick_chan #(
            .SEL_W    (SEL_W),
            .DIV_BASE (DIV_BASE),
            .SHW      (SHW),
            .CNT_W    (CNT_W),
            .EXT_MASK (EXT_MASK)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_tick (pre_tick[G]),
            .ext_in   (ext_tick[G]),
            .sel      (cfg_sel[c*SEL_W +: SEL_W]),
            .tick     (tick[c])
        );

        // R5 / R1: a strobe needs a cause in its own group one clock earlier
        tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> $past(pre_tick[G] | ext_tick[G]));
    end

endmodule

// File: tb/pwm_tick_gen_test.sv
module pwm_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_pre = '0;
    logic [19:0] cfg_sel = '0;
    logic [1:0]  ext_tick = '0;
    logic [4:0]  tick;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int    ch;
        int    exp;
        string req;
    } exp_item_t;

    exp_item_t sb_q[$];
    bit        mon_busy = 1'b0;

    always #2 clk = ~clk;

    pwm_tick_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_pre  (cfg_pre),
        .cfg_sel  (cfg_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_period(input int ch, input int exp, input string req);
        exp_item_t it;
        it.ch  = ch;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        while (sb_q.size() > 0 || mon_busy) @(negedge clk);
    endtask

    task automatic wait_tick(input int ch);
        @(negedge clk);
        while (!tick[ch]) @(negedge clk);
    endtask

    // Monitor: measures the interval between two strobes of the queued channel
    initial begin
        forever begin
            exp_item_t it;
            int        n;
            @(negedge clk);
            if (sb_q.size() > 0) begin
                mon_busy = 1'b1;
                it = sb_q.pop_front();
                while (!tick[it.ch]) @(negedge clk);
                n = 0;
                do begin
                    @(negedge clk);
                    n++;
                end while (!tick[it.ch]);
                check(it.req, n, it.exp);
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R9: reset state
        repeat (5) @(negedge clk);
        check("R9 strobes low in reset", int'(tick), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 5; c++) expect_period(c, 2, "R9 post-reset period");
        drain();

        // R1 R3 R4: distinct prescaler and select per channel
        cfg_pre = {8'd4, 8'd2};
        cfg_sel = {4'h0, 4'h3, 4'h2, 4'h0, 4'h1};
        repeat (300) @(negedge clk);
        expect_period(0, 12, "R4 ch0 code1 preA 2");
        expect_period(1, 6,  "R3 ch1 code0 preA 2");
        expect_period(2, 40, "R1 ch2 code2 preB 4");
        expect_period(3, 80, "R4 ch3 code3 preB 4");
        expect_period(4, 10, "R1 ch4 code0 preB 4");
        drain();

        // R4 code 5 divides; R5 external mode on ch0 and ch4
        cfg_pre = '0;
        cfg_sel = {4'h4, 4'h5, 4'h1, 4'h0, 4'h4};
        repeat (300) @(negedge clk);
        expect_period(3, 64, "R4 ch3 unmasked code5");
        expect_period(2, 4,  "R2 ch2 prescale 0");
        drain();
        @(negedge clk);
        ext_tick = 2'b10;
        @(negedge clk);
        ext_tick = 2'b00;
        check("R5 ch4 follows ext1", int'(tick[4]), 1);
        check("R5 ch0 ignores ext1", int'(tick[0]), 0);
        @(negedge clk);
        check("R5 ch4 low after pulse", int'(tick[4]), 0);
        ext_tick = 2'b01;
        @(negedge clk);
        ext_tick = 2'b00;
        check("R5 ch0 follows ext0", int'(tick[0]), 1);
        check("R5 ch4 ignores ext0", int'(tick[4]), 0);

        // R6: prescaler change deferred to terminal count
        cfg_pre = 16'h0009;
        cfg_sel = '0;
        repeat (300) @(negedge clk);
        expect_period(1, 20, "R2 ch1 preA 9");
        drain();
        wait_tick(1);
        repeat (3) @(negedge clk);
        cfg_pre = 16'h0000;
        n = 3;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[1]);
        check("R6 interval across prescaler change", n, 11);

        // R7: select change deferred to end of divide period
        cfg_sel = 20'h00003;
        repeat (300) @(negedge clk);
        wait_tick(0);
        repeat (2) @(negedge clk);
        cfg_sel = '0;
        n = 2;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[0]);
        check("R7 old divide finishes", n, 16);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[0]);
        check("R7 new divide applies", n, 2);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule